// File: doc/BRIEF.md
# Host Control and Status Register Bank

This block is the host's programmed-I/O window into the accelerator's global control state. Each access is a single 32-bit read or write at a word address. Writes update the settings that drive the surrounding logic: the polarity and length of a user-logic soft reset, a 2-bit user-clock rate code, the DMA length and DRAM address words, and a set of crossbar route words. Reads return those settings, live monitor readings and per-channel completion flags. The read data arrives one cycle after the request and is marked by a read-valid strobe.

The soft reset runs as a two-state machine. In `RS_IDLE` the output sits at the inactive level for the programmed polarity. A write of 1 to bit 0 of the reset-trigger register takes the transition *launch* into `RS_ACTIVE`. The output then holds the active level for the programmed number of cycles, and the transition *expire* returns it to `RS_IDLE`.

Each DMA channel has a sticky completion flag. Software clears a flag by writing 1 to its bit. The interrupt output is the OR of the flags whose enable bits are set.

Word address map:
- 0x00: control. Bit 0 is the polarity, bits 2:1 are the clock code.
- 0x01: reset trigger.
- 0x02: pulse length.
- 0x03: DMA length.
- 0x04: DRAM address.
- 0x05: flag status.
- 0x06: flag enable.
- 0x08 to 0x0B: route words.
- 0x10 to 0x13: monitor readings.

Top module: `host_ctrl_regs`

## Requirements
- R1: A read request produces `rd_valid_o` high for exactly one cycle, in the cycle after the request, with `rd_data_o` valid. A write request never raises `rd_valid_o`.
- R2: In the control register at 0x00, bit 0 selects the soft-reset polarity (1 means active-high) and bits 2:1 hold the clock code (00=250, 01=200, 10=150, 11=100 MHz), which drives `clk_sel_o`. Bits 31:3 read as zero.
- R3: Writing 1 to bit 0 of 0x01 while in `RS_IDLE` holds `usr_rst_o` at its active level for N cycles and then releases it. N is the length register at 0x02 (bits 15:0, reset value 16), and a length of 0 acts as 1. A trigger written while the pulse runs neither restarts nor stretches it.
- R4: While no pulse runs, `usr_rst_o` equals the inverse of the polarity bit. During a pulse it equals the polarity bit.
- R5: The DMA length (0x03) and DRAM address (0x04) are read/write words that drive `dma_len_o` and `dram_addr_o`.
- R6: The route words at 0x08 + k are read/write and drive slice k of `route_o`.
- R7: A read of 0x10 + k returns slice k of `mon_i` as sampled at the request. Writes to these addresses have no effect.
- R8: Each flag at 0x05 (bit c for channel c) is set by `done_i[c]` and stays set until a write with bit c = 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq_o` is high when any flag is set whose bit in the enable register at 0x06 is also 1.
- R10: A read of an unmapped address returns 0xDEADBEEF. A write to one changes nothing.
- R11: After reset:
  - control reads 0x00000001;
  - the length register reads 16;
  - the DMA length, DRAM address, route words, flags and enables are zero;
  - `usr_rst_o` is 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | 32 | Read data |
| usr_rst_o | output | 1 | Soft reset to user logic |
| clk_sel_o | output | 2 | User clock rate code |
| dma_len_o | output | 32 | DMA transfer length |
| dram_addr_o | output | 32 | DRAM address |
| route_o | output | 32*N_ROUTE | Crossbar route words |
| mon_i | input | 32*N_MON | Monitor readings |
| done_i | input | N_CH | Per-channel completion pulses |
| irq_o | output | 1 | Completion interrupt |

## Verification
A completion pulse and a write-one-to-clear of the same flag can fall in the same cycle. The bench drives `done_i` for a channel in the very cycle that clears that channel's bit, then reads the status back. It judges the result correct only if the bit is still set, and it checks that a clear with no pulse in that cycle does empty the flag. A second overlap is a reset-trigger write that lands in the middle of a running pulse. That case is judged by counting the active cycles: the count must equal the programmed length exactly.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
    localparam int unsigned A_CTRL     = 0;
    localparam int unsigned A_RST_GO   = 1;
    localparam int unsigned A_RST_LEN  = 2;
    localparam int unsigned A_DMA_LEN  = 3;
    localparam int unsigned A_DRAM     = 4;
    localparam int unsigned A_FLAGS    = 5;
    localparam int unsigned A_FLAG_EN  = 6;
    localparam int unsigned ROUTE_BASE = 8;
    localparam int unsigned MON_BASE   = 16;
    localparam logic [31:0] MISS_WORD  = 32'hDEAD_BEEF;

    typedef enum logic {
        RS_IDLE   = 1'b0,
        RS_ACTIVE = 1'b1
    } rst_state_t;

    typedef struct packed {
        logic ctrl;
        logic go;
        logic len;
        logic dma_len;
        logic dram;
        logic flags;
        logic flag_en;
    } fixed_sel_t;
endpackage

// File: rtl/hrb_decode.sv
module hrb_decode
    import hrb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned N_ROUTE = 4,
    parameter int unsigned N_MON   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    output fixed_sel_t        sel_o,
    output logic [N_ROUTE-1:0] route_hit_o,
    output logic [N_MON-1:0]   mon_hit_o,
    output logic               mapped_o
);
    always_comb begin
        sel_o.ctrl    = (addr_i == ADDR_W'(A_CTRL));
        sel_o.go      = (addr_i == ADDR_W'(A_RST_GO));
        sel_o.len     = (addr_i == ADDR_W'(A_RST_LEN));
        sel_o.dma_len = (addr_i == ADDR_W'(A_DMA_LEN));
        sel_o.dram    = (addr_i == ADDR_W'(A_DRAM));
        sel_o.flags   = (addr_i == ADDR_W'(A_FLAGS));
        sel_o.flag_en = (addr_i == ADDR_W'(A_FLAG_EN));
    end

    for (genvar k = 0; k < N_ROUTE; k++) begin : g_route_hit
        assign route_hit_o[k] = (addr_i == ADDR_W'(ROUTE_BASE + k));
    end

    for (genvar k = 0; k < N_MON; k++) begin : g_mon_hit
        assign mon_hit_o[k] = (addr_i == ADDR_W'(MON_BASE + k));
    end

    assign mapped_o = (|sel_o) | (|route_hit_o) | (|mon_hit_o);
endmodule

// File: rtl/hrb_soft_reset.sv
module hrb_soft_reset
    import hrb_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             pol_i,
    output logic             usr_rst_o,
    output logic             busy_o
);
    rst_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: begin
                if (go_i) begin
                    state_d = RS_ACTIVE;
                    cnt_d   = (len_i == '0) ? '0 : len_i - CNT_W'(1);
                end
            end
            RS_ACTIVE: begin
                if (cnt_q == '0) state_d = RS_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o    = (state_q == RS_ACTIVE);
        usr_rst_o = busy_o ? pol_i : ~pol_i;
    end

    // R3
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i));

    // R3
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0) |=> busy_o);
endmodule

// File: rtl/hrb_irq_bank.sv
module hrb_irq_bank #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] done_i,
    input  logic            clr_we_i,
    input  logic [N_CH-1:0] clr_mask_i,
    input  logic [N_CH-1:0] en_i,
    output logic [N_CH-1:0] flags_o,
    output logic            irq_o
);
    for (genvar c = 0; c < N_CH; c++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                        flag_q <= 1'b0;
            else if (done_i[c])                flag_q <= 1'b1;
            else if (clr_we_i && clr_mask_i[c]) flag_q <= 1'b0;
        end
        assign flags_o[c] = flag_q;

        // R8
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_i[c] |=> flag_q);

        // R8
        flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_mask_i[c] && !done_i[c]) |=> !flag_q);

        // R8
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !(clr_we_i && clr_mask_i[c])) |=> flag_q);
    end

    assign irq_o = |(flags_o & en_i);
endmodule

// File: rtl/host_ctrl_regs.sv
module host_ctrl_regs
    import hrb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned N_CH        = 4,
    parameter int unsigned N_ROUTE     = 4,
    parameter int unsigned N_MON       = 4,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned RST_LEN_DEF = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [31:0]          req_wdata_i,
    output logic                 rd_valid_o,
    output logic [31:0]          rd_data_o,
    output logic                 usr_rst_o,
    output logic [1:0]           clk_sel_o,
    output logic [31:0]          dma_len_o,
    output logic [31:0]          dram_addr_o,
    output logic [32*N_ROUTE-1:0] route_o,
    input  logic [32*N_MON-1:0]   mon_i,
    input  logic [N_CH-1:0]       done_i,
    output logic                 irq_o
);
    localparam logic [CNT_W-1:0] LEN_RESET = CNT_W'(RST_LEN_DEF);

    fixed_sel_t        sel;
    logic [N_ROUTE-1:0] route_hit;
    logic [N_MON-1:0]   mon_hit;
    logic               mapped;
    logic               wr, rd;

    logic             pol_q;
    logic [1:0]       clk_q;
    logic [CNT_W-1:0] len_q;
    logic [31:0]      dma_len_q, dram_q;
    logic [N_CH-1:0]  en_q, flags;
    logic [31:0]      route_q [N_ROUTE];
    logic             busy;
    logic [31:0]      rd_mux;

    assign wr = req_valid_i &  req_write_i;
    assign rd = req_valid_i & ~req_write_i;

    hrb_decode #(.ADDR_W(ADDR_W), .N_ROUTE(N_ROUTE), .N_MON(N_MON)) u_dec (
        .addr_i(req_addr_i), .sel_o(sel), .route_hit_o(route_hit),
        .mon_hit_o(mon_hit), .mapped_o(mapped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q     <= 1'b1;
            clk_q     <= 2'b00;
            len_q     <= LEN_RESET;
            dma_len_q <= '0;
            dram_q    <= '0;
            en_q      <= '0;
        end else if (wr) begin
            if (sel.ctrl) begin
                pol_q <= req_wdata_i[0];
                clk_q <= req_wdata_i[2:1];
            end
            if (sel.len)     len_q     <= req_wdata_i[CNT_W-1:0];
            if (sel.dma_len) dma_len_q <= req_wdata_i;
            if (sel.dram)    dram_q    <= req_wdata_i;
            if (sel.flag_en) en_q      <= req_wdata_i[N_CH-1:0];
        end
    end

    for (genvar k = 0; k < N_ROUTE; k++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)                    route_q[k] <= '0;
            else if (wr && route_hit[k])   route_q[k] <= req_wdata_i;
        end
        assign route_o[32*k +: 32] = route_q[k];
    end

    hrb_soft_reset #(.CNT_W(CNT_W)) u_rst (
        .clk(clk), .rst_n(rst_n),
        .go_i(wr && sel.go && req_wdata_i[0]),
        .len_i(len_q), .pol_i(pol_q),
        .usr_rst_o(usr_rst_o), .busy_o(busy)
    );

    hrb_irq_bank #(.N_CH(N_CH)) u_irq (
        .clk(clk), .rst_n(rst_n), .done_i(done_i),
        .clr_we_i(wr && sel.flags), .clr_mask_i(req_wdata_i[N_CH-1:0]),
        .en_i(en_q), .flags_o(flags), .irq_o(irq_o)
    );

    always_comb begin
        rd_mux = '0;
        if (!mapped)          rd_mux = MISS_WORD;
        if (sel.ctrl)         rd_mux = {29'b0, clk_q, pol_q};
        if (sel.go)           rd_mux = {31'b0, busy};
        if (sel.len)          rd_mux = 32'(len_q);
        if (sel.dma_len)      rd_mux = dma_len_q;
        if (sel.dram)         rd_mux = dram_q;
        if (sel.flags)        rd_mux = 32'(flags);
        if (sel.flag_en)      rd_mux = 32'(en_q);
        for (int k = 0; k < N_ROUTE; k++)
            if (route_hit[k]) rd_mux = route_q[k];
        for (int k = 0; k < N_MON; k++)
            if (mon_hit[k])   rd_mux = mon_i[32*k +: 32];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd;
            if (rd) rd_data_o <= rd_mux;
        end
    end

    assign clk_sel_o   = clk_q;
    assign dma_len_o   = dma_len_q;
    assign dram_addr_o = dram_q;

    // R1
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rd_valid_o);

    // R1
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rd_valid_o);

    // R10
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rd_data_o == MISS_WORD));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mapped) |=> ($stable(dma_len_o) && $stable(dram_addr_o) && $stable(route_o) && $stable(clk_sel_o)));
endmodule

// File: tb/host_ctrl_regs_tb_top.sv
module host_ctrl_regs_tb_top;
    localparam int ADDR_W = 6, N_CH = 4, N_ROUTE = 4, N_MON = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rd_valid;
    logic [31:0] rd_data;
    logic usr_rst;
    logic [1:0] clk_sel;
    logic [31:0] dma_len, dram_addr;
    logic [32*N_ROUTE-1:0] route;
    logic [32*N_MON-1:0] mon = {32'h0000_0D04, 32'h0000_0C03, 32'h0000_0B02, 32'h0000_0A01};
    logic [N_CH-1:0] done = '0;
    logic irq;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    host_ctrl_regs #(.ADDR_W(ADDR_W), .N_CH(N_CH), .N_ROUTE(N_ROUTE), .N_MON(N_MON)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .usr_rst_o(usr_rst), .clk_sel_o(clk_sel),
        .dma_len_o(dma_len), .dram_addr_o(dram_addr), .route_o(route),
        .mon_i(mon), .done_i(done), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = ADDR_W'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        req_valid = 1; req_write = 0; req_addr = ADDR_W'(a);
        @(negedge clk);
        req_valid = 0;
        chk("R1 rd_valid", 32'(rd_valid), 32'd1);
        d = rd_data;
        @(negedge clk);
        chk("R1 strobe one cycle", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R11 usr_rst", 32'(usr_rst), 0);
        chk("R11 irq", 32'(irq), 0);
        chk("R11 rd_valid", 32'(rd_valid), 0);
        rd(0, d); chk("R11 ctrl", d, 32'h1);
        rd(2, d); chk("R11 len", d, 32'd16);
        rd(5, d); chk("R11 flags", d, 0);
        chk("R11 dma_len", dma_len, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(0, 32'hFFFF_FFFD);   // pol=1, code=10
        chk("R2 clk_sel 150", 32'(clk_sel), 32'd2);
        rd(0, d); chk("R2 reserved zero", d, 32'h5);
        wr(0, 32'h7);           // code=11
        chk("R2 clk_sel 100", 32'(clk_sel), 32'd3);
        chk("R4 idle high-pol", 32'(usr_rst), 0);
        wr(0, 32'h1);
        req_valid = 1; req_write = 1; req_addr = 0; req_wdata = 0;  // check no rd_valid on write
        @(negedge clk);
        req_valid = 0;
        chk("R1 write no strobe", 32'(rd_valid), 0);
        chk("R4 idle low-pol", 32'(usr_rst), 1);
        wr(0, 32'h1);
    endtask

    task automatic t_pulse(logic pol, int len, int expn, bit retrig);
        int n = 0;
        wr(0, {31'b0, pol});
        wr(2, 32'(len));
        wr(1, 32'h1);
        while (usr_rst == pol && n < 100) begin
            n++;
            if (retrig && n == 2) wr(1, 32'h1);
            else @(negedge clk);
        end
        chk("R3 pulse length", 32'(n), 32'(expn));
        chk("R4 release level", 32'(usr_rst), 32'(!pol));
    endtask

    task automatic t_data();
        logic [31:0] d;
        wr(3, 32'h0001_0000); wr(4, 32'h8000_0040);
        chk("R5 dma_len port", dma_len, 32'h0001_0000);
        chk("R5 dram port", dram_addr, 32'h8000_0040);
        rd(4, d); chk("R5 dram readback", d, 32'h8000_0040);
        for (int k = 0; k < N_ROUTE; k++) wr(8 + k, 32'h100 + 32'(k));
        chk("R6 route slice 2", route[64 +: 32], 32'h102);
        rd(11, d); chk("R6 route readback", d, 32'h103);
        wr(17, 32'h1234_5678);
        rd(17, d); chk("R7 monitor ro", d, 32'h0000_0B02);
        mon[96 +: 32] = 32'h0000_0E55;
        rd(19, d); chk("R7 monitor live", d, 32'h0000_0E55);
        rd(7, d); chk("R10 unmapped read", d, 32'hDEAD_BEEF);
        wr(40, 32'hFFFF_FFFF);
        chk("R10 unmapped write dma", dma_len, 32'h0001_0000);
        rd(9, d); chk("R10 unmapped write route", d, 32'h101);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        done = 4'b0101; @(negedge clk); done = 0;
        rd(5, d); chk("R8 sticky flags", d, 32'h5);
        chk("R9 masked", 32'(irq), 0);
        wr(6, 32'h4);
        chk("R9 enabled irq", 32'(irq), 1);
        wr(5, 32'h4);
        chk("R9 irq after clear", 32'(irq), 0);
        rd(5, d); chk("R8 w1c one bit", d, 32'h1);
        // same-cycle set and clear of channel 1
        done = 4'b0010;
        req_valid = 1; req_write = 1; req_addr = 5; req_wdata = 32'h2;
        @(negedge clk);
        req_valid = 0; req_write = 0; done = 0;
        rd(5, d); chk("R8 set wins", d, 32'h3);
        wr(5, 32'hF);
        rd(5, d); chk("R8 clear all", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_pulse(1'b1, 5, 5, 0);
        t_pulse(1'b0, 7, 7, 0);
        t_pulse(1'b1, 6, 6, 1);
        t_pulse(1'b1, 0, 1, 0);
        t_data();
        t_irq();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule